// File: doc/BRIEF.md
# Power-Down Mode Control Unit

This block sequences the operating modes of a small microcontroller. It keeps one 8-bit standby control byte on a plain read/write bus. When the CPU core executes its sleep instruction it raises `sleep_req` for one cycle. The block then picks the next mode from three inputs: the current mode, the standby bit of the control byte and a 2-bit qualifier. A wake-up request from the interrupt logic moves the block back to a run mode. When the main oscillator has been stopped, it first passes through a timed clock-settling wait whose length is selected in the control byte.

The same byte selects a system clock ratio. In the full-speed run mode the block issues a clock enable on every cycle. With a division code it issues a one-cycle enable pulse every 2, 4, 8, 16 or 32 cycles. A new ratio only takes hold at the end of the period that is running, so no period is ever cut short. The block refuses to enter the two subclock modes (subactive and watch) while a division code is set. In that case it stays in its mode and flags the refusal.

There is no data stream here, so every pin is a plain control or status level or pulse and no valid/ready handshake is used. The bus write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. `bus_rdata` always shows the stored byte.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Control byte layout: bit 7 = standby select, bits 6:4 = settle-time code, bit 3 = reserved, bits 2:0 = clock code. After reset the byte reads 0x00, `pwr_mode` is 0 (full speed) and `clk_en` is high every cycle.
- R2: Bit 3 always reads 0, and writing 1 to it has no effect (writing 0xFF reads back 0xF7).
- R3: Mode codes on `pwr_mode` are: 0 full speed, 1 divided speed, 2 sleep, 3 software standby, 4 subactive, 5 subsleep, 6 watch, 7 clock-settling wait. In mode 0 or 1 with standby select 0, a `sleep_req` moves the block to sleep (2) at that clock edge. A `wake_irq` in sleep returns it to the run mode at the next edge, with no settling wait.
- R4: In mode 0 or 1 with standby select 1, `sleep_req` moves the block according to `mode_qual`: 00 to software standby (3), 01 to subactive (4), and 1x to watch (6).
- R5: In subactive with standby select 0, `sleep_req` goes to subsleep (5), and `wake_irq` in subsleep returns to subactive at once. In subactive with standby select 1, `mode_qual[1]`=1 goes to watch, while `mode_qual[1]`=0 goes to the settling wait and then to the run mode.
- R6: Mode changes, including those caused by `wake_irq`, never alter the control byte. It changes only by a bus write.
- R7: A `wake_irq` in software standby or watch, and a subactive exit to full speed, enter mode 7 for exactly 2^(8+2·code) cycles, where code is the settle-time field. `settle_done` is high in the last of those cycles, and the block then enters the run mode.
- R8: Clock code 000 gives `clk_en` on every cycle. Codes 001 to 101 give a one-cycle `clk_en` pulse every 2^code cycles and make `pwr_mode` read 1.
- R9: Clock codes 110 and 111 are not divide ratios. They behave as full speed: `clk_en` is high every cycle and `pwr_mode` reads 0.
- R10: A new clock code takes effect only at the end of the enable period already running. After a write, the next pulse comes a full old period after the previous one.
- R11: A request to enter subactive or watch while the clock code is nonzero is refused. The mode stays as it was, and `trans_err` is high for the one cycle after that edge.
- R12: `clk_en` is low in every mode other than 0 and 1. `sleep_req` is ignored in modes 2, 3, 5, 6 and 7. `wake_irq` is ignored in run modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, used with `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control byte |
| sleep_req | input | 1 | Sleep instruction executed (one-cycle pulse) |
| mode_qual | input | 2 | Chooses among targets allowed by one standby value |
| wake_irq | input | 1 | Wake-up interrupt request |
| pwr_mode | output | 3 | Current mode code (see R3) |
| settle_done | output | 1 | High in the last cycle of the settling wait |
| trans_err | output | 1 | One-cycle flag for a refused transition |
| clk_en | output | 1 | System clock enable for the bus master |

## Verification
A corrupted mode register shows on `pwr_mode` at the very edge that loads it, and on `clk_en` at the same edge, because the enable is gated by the run state. A timer that is loaded with the wrong value, or that stops early, shows as a settling wait whose cycle count is off. That error appears only when the wait ends, at least 256 cycles later, so the bench counts every cycle of mode 7. A wrongly latched divide ratio first shows at the next pulse, up to 32 cycles after the write, so the spacing between pulses is measured across the write and after it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_FULL     = 3'd0,
    PM_DIVIDED  = 3'd1,
    PM_SLEEP    = 3'd2,
    PM_SWSTBY   = 3'd3,
    PM_SUBACT   = 3'd4,
    PM_SUBSLEEP = 3'd5,
    PM_WATCH    = 3'd6,
    PM_SETTLE   = 3'd7
  } pm_mode_e;

  typedef struct packed {
    logic       stby;
    logic [2:0] settle_code;
    logic       rsvd;
    logic [2:0] clk_code;
  } pm_ctrl_t;

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pm_ctrl_t wdata,
  output pm_ctrl_t ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.stby        <= wdata.stby;
      ctrl.settle_code <= wdata.settle_code;
      ctrl.rsvd        <= 1'b0;
      ctrl.clk_code    <= wdata.clk_code;
    end
  end

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int BASE_SHIFT = 8,
  parameter int STEP_SHIFT = 2,
  parameter int CODE_W     = 3,
  parameter int CAP_CODE   = (1 << CODE_W) - 1,
  localparam int NUM_CODES = 1 << CODE_W,
  localparam int CNT_W     = BASE_SHIFT + STEP_SHIFT * CAP_CODE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              done
);

  logic [CNT_W-1:0] load_tab [NUM_CODES];
  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_load
    localparam int EFF = (i > CAP_CODE) ? CAP_CODE : i;
    localparam int SH  = BASE_SHIFT + STEP_SHIFT * EFF;
    assign load_tab[i] = CNT_W'(1) << SH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= load_tab[code];
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int CODE_W    = 3,
  parameter int MAX_SHIFT = 5,
  localparam int CNT_W    = MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel,
  output logic              sel_divides,
  output logic              en
);

  logic [CODE_W-1:0] shift_new;
  logic [CODE_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    last_val;

  always_comb begin
    if ((sel != '0) && (int'(sel) <= MAX_SHIFT)) shift_new = sel;
    else                                         shift_new = '0;
  end

  assign sel_divides = (shift_new != '0);
  assign last_val    = ((CNT_W+1)'(1) << shift_q) - (CNT_W+1)'(1);
  assign en          = ({1'b0, cnt} == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shift_q <= '0;
    end else if (en) begin
      cnt     <= '0;
      shift_q <= shift_new;
    end else begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_req,
  input  logic     wake_irq,
  input  logic [1:0] qual,
  input  logic     stby,
  input  logic     clk_code_nz,
  input  logic     divides,
  input  logic     settle_done,
  output logic     settle_start,
  output logic     running,
  output logic     err,
  output pm_mode_e mode
);

  pm_mode_e st, nxt;
  logic     blocked;

  always_comb begin
    nxt          = st;
    settle_start = 1'b0;
    blocked      = 1'b0;
    unique case (st)
      PM_FULL: begin
        if (sleep_req) begin
          if (!stby)                nxt = PM_SLEEP;
          else if (qual == 2'b00)   nxt = PM_SWSTBY;
          else if (clk_code_nz)     blocked = 1'b1;
          else                      nxt = qual[1] ? PM_WATCH : PM_SUBACT;
        end
      end
      PM_SUBACT: begin
        if (sleep_req) begin
          if (!stby) begin
            nxt = PM_SUBSLEEP;
          end else if (qual[1]) begin
            if (clk_code_nz) blocked = 1'b1;
            else             nxt = PM_WATCH;
          end else begin
            nxt          = PM_SETTLE;
            settle_start = 1'b1;
          end
        end
      end
      PM_SLEEP:    if (wake_irq) nxt = PM_FULL;
      PM_SUBSLEEP: if (wake_irq) nxt = PM_SUBACT;
      PM_SWSTBY, PM_WATCH: begin
        if (wake_irq) begin
          nxt          = PM_SETTLE;
          settle_start = 1'b1;
        end
      end
      PM_SETTLE:   if (settle_done) nxt = PM_FULL;
      default:     nxt = PM_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PM_FULL;
      err <= 1'b0;
    end else begin
      st  <= nxt;
      err <= blocked;
    end
  end

  assign running = (st == PM_FULL);
  assign mode    = (running && divides) ? PM_DIVIDED : st;

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int BASE_SHIFT    = 8,
  parameter int STEP_SHIFT    = 2,
  parameter int MAX_DIV_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sleep_req,
  input  logic [1:0] mode_qual,
  input  logic       wake_irq,
  output logic [2:0] pwr_mode,
  output logic       settle_done,
  output logic       trans_err,
  output logic       clk_en
);

  pm_ctrl_t ctrl;
  pm_mode_e mode;
  logic     settle_start, running, divides, div_en;

  pmc_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_sel && bus_wr),
    .wdata (pm_ctrl_t'(bus_wdata)),
    .ctrl  (ctrl)
  );

  pmc_settle_timer #(
    .BASE_SHIFT (BASE_SHIFT),
    .STEP_SHIFT (STEP_SHIFT),
    .CODE_W     (3)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .code  (ctrl.settle_code),
    .done  (settle_done)
  );

  pmc_clk_div #(
    .CODE_W    (3),
    .MAX_SHIFT (MAX_DIV_SHIFT)
  ) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (ctrl.clk_code),
    .sel_divides (divides),
    .en          (div_en)
  );

  pmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .wake_irq     (wake_irq),
    .qual         (mode_qual),
    .stby         (ctrl.stby),
    .clk_code_nz  (ctrl.clk_code != 3'd0),
    .divides      (divides),
    .settle_done  (settle_done),
    .settle_start (settle_start),
    .running      (running),
    .err          (trans_err),
    .mode         (mode)
  );

  assign bus_rdata = ctrl;
  assign pwr_mode  = mode;
  assign clk_en    = div_en && running;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic [2:0] pwr_mode,
  input logic       settle_done,
  input logic       trans_err,
  input logic       clk_en
);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[3] == 1'b0);

  assert_byte_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(bus_rdata));

  assert_done_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> pwr_mode == 3'd7);

  assert_done_then_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> (pwr_mode == 3'd0 || pwr_mode == 3'd1));

  assert_refused_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trans_err |-> (pwr_mode == 3'd0 || pwr_mode == 3'd1 || pwr_mode == 3'd4));

  assert_watch_entry_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd6 && $past(pwr_mode) != 3'd6) |-> $past(bus_rdata[2:0]) == 3'd0);

  assert_subact_entry_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd4 && ($past(pwr_mode) == 3'd0 || $past(pwr_mode) == 3'd1))
      |-> $past(bus_rdata[2:0]) == 3'd0);

  assert_clk_en_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_mode == 3'd0 || pwr_mode == 3'd1) |-> !clk_en);

endmodule

bind pwr_mode_ctl pmc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .pwr_mode    (pwr_mode),
  .settle_done (settle_done),
  .trans_err   (trans_err),
  .clk_en      (clk_en)
);

// File: tb/test_pwr_mode_ctl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sleep_req = 1'b0, wake_irq = 1'b0;
  logic [1:0] mode_qual = '0;
  logic [2:0] pwr_mode;
  logic       settle_done, trans_err, clk_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .mode_qual(mode_qual), .wake_irq(wake_irq), .pwr_mode(pwr_mode),
    .settle_done(settle_done), .trans_err(trans_err), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_sleep(input logic [1:0] q);
    sleep_req = 1'b1; mode_qual = q;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic do_wake();
    wake_irq = 1'b1;
    tick();
    wake_irq = 1'b0;
  endtask

  // called right after the edge that entered the wait
  task automatic count_settle(input string req, input int exp_len);
    int n = 0;
    int done_at = -1;
    while (pwr_mode == 3'd7 && n < 20000) begin
      if (settle_done) done_at = n;
      tick();
      n++;
    end
    check(n == exp_len, req, n, exp_len);
    check(done_at == exp_len - 1, req, done_at, exp_len - 1);
    check(pwr_mode == 3'd0, req, pwr_mode, 0);
  endtask

  task automatic measure_gap(output int gap);
    int guard = 0;
    while (!clk_en && guard < 100) begin tick(); guard++; end
    gap = 0;
    do begin tick(); gap++; end while (!clk_en && gap < 100);
  endtask

  task automatic t_reset();
    check(bus_rdata == 8'h00, "R1 reset byte", bus_rdata, 0);
    check(pwr_mode == 3'd0, "R1 reset mode", pwr_mode, 0);
    check(clk_en == 1'b1, "R1 reset clk_en", clk_en, 1);
    check(trans_err == 1'b0 && settle_done == 1'b0, "R1 reset flags", trans_err, 0);
  endtask

  task automatic t_reserved();
    write_reg(8'hFF);
    check(bus_rdata == 8'hF7, "R2 reserved bit", bus_rdata, 8'hF7);
    write_reg(8'h00);
    check(bus_rdata == 8'h00, "R1 clear", bus_rdata, 0);
  endtask

  task automatic t_sleep();
    write_reg(8'h00);
    do_sleep(2'b00);
    check(pwr_mode == 3'd2, "R3 enter sleep", pwr_mode, 2);
    check(clk_en == 1'b0, "R12 clk_en off in sleep", clk_en, 0);
    do_sleep(2'b01);
    check(pwr_mode == 3'd2, "R12 sleep_req ignored in sleep", pwr_mode, 2);
    do_wake();
    check(pwr_mode == 3'd0, "R3 wake from sleep no wait", pwr_mode, 0);
    do_wake();
    check(pwr_mode == 3'd0, "R12 wake ignored in run", pwr_mode, 0);
    write_reg(8'h03);
    do_sleep(2'b00);
    check(pwr_mode == 3'd2, "R3 sleep from divided", pwr_mode, 2);
    do_wake();
    check(pwr_mode == 3'd1, "R3 back to divided", pwr_mode, 1);
    write_reg(8'h00);
  endtask

  task automatic t_standby();
    write_reg(8'h80);
    do_sleep(2'b00);
    check(pwr_mode == 3'd3, "R4 enter software standby", pwr_mode, 3);
    do_sleep(2'b10);
    check(pwr_mode == 3'd3, "R12 sleep_req ignored in standby", pwr_mode, 3);
    do_wake();
    count_settle("R7 standby wait code0", 256);
    check(bus_rdata == 8'h80, "R6 byte kept after wake", bus_rdata, 8'h80);
  endtask

  task automatic t_watch();
    write_reg(8'h90);
    do_sleep(2'b10);
    check(pwr_mode == 3'd6, "R4 enter watch", pwr_mode, 6);
    check(clk_en == 1'b0, "R12 clk_en off in watch", clk_en, 0);
    do_wake();
    count_settle("R7 watch wait code1", 1024);
    check(bus_rdata == 8'h90, "R6 byte kept after watch", bus_rdata, 8'h90);
  endtask

  task automatic t_subclock();
    write_reg(8'h80);
    do_sleep(2'b01);
    check(pwr_mode == 3'd4, "R4 enter subactive", pwr_mode, 4);
    write_reg(8'h00);
    do_sleep(2'b00);
    check(pwr_mode == 3'd5, "R5 enter subsleep", pwr_mode, 5);
    do_wake();
    check(pwr_mode == 3'd4, "R5 subsleep wake to subactive", pwr_mode, 4);
    write_reg(8'h80);
    do_sleep(2'b10);
    check(pwr_mode == 3'd6, "R5 subactive to watch", pwr_mode, 6);
    do_wake();
    count_settle("R7 watch wait from subclock", 256);
    do_sleep(2'b01);
    check(pwr_mode == 3'd4, "R4 subactive again", pwr_mode, 4);
    do_sleep(2'b00);
    check(pwr_mode == 3'd7, "R5 subactive exit enters wait", pwr_mode, 7);
    tick();
    begin
      int rest = 1;
      while (pwr_mode == 3'd7 && rest < 20000) begin tick(); rest++; end
      check(rest == 256, "R5 subactive exit wait length", rest, 256);
    end
    check(pwr_mode == 3'd0, "R5 subactive exit to full", pwr_mode, 0);
  endtask

  task automatic t_blocked();
    write_reg(8'h83);
    check(pwr_mode == 3'd1, "R8 divided mode code", pwr_mode, 1);
    do_sleep(2'b01);
    check(pwr_mode == 3'd1, "R11 subactive refused", pwr_mode, 1);
    check(trans_err == 1'b1, "R11 error flag", trans_err, 1);
    tick();
    check(trans_err == 1'b0, "R11 error one cycle", trans_err, 0);
    do_sleep(2'b11);
    check(pwr_mode == 3'd1 && trans_err, "R11 watch refused", pwr_mode, 1);
    write_reg(8'h80);
    do_sleep(2'b01);
    check(pwr_mode == 3'd4, "R4 subactive entry", pwr_mode, 4);
    write_reg(8'h82);
    do_sleep(2'b10);
    check(pwr_mode == 3'd4 && trans_err, "R11 watch refused from subactive", pwr_mode, 4);
    write_reg(8'h80);
    do_sleep(2'b00);
    count_settle("R7 exit after refusal", 256);
  endtask

  task automatic t_divide();
    int g;
    write_reg(8'h00);
    measure_gap(g);
    check(g == 1, "R8 full rate", g, 1);
    write_reg(8'h03);
    measure_gap(g); measure_gap(g);
    check(g == 8, "R8 divide by 8", g, 8);
    write_reg(8'h01);
    measure_gap(g); measure_gap(g);
    check(g == 2, "R8 divide by 2", g, 2);
    write_reg(8'h05);
    measure_gap(g); measure_gap(g);
    check(g == 32, "R8 divide by 32", g, 32);
    write_reg(8'h06);
    measure_gap(g); measure_gap(g);
    check(g == 1, "R9 code 110 full rate", g, 1);
    check(pwr_mode == 3'd0, "R9 code 110 mode", pwr_mode, 0);
    write_reg(8'h07);
    measure_gap(g); measure_gap(g);
    check(g == 1 && pwr_mode == 3'd0, "R9 code 111 full rate", g, 1);
  endtask

  task automatic t_wrap();
    int g;
    int n = 0;
    write_reg(8'h05);
    measure_gap(g); measure_gap(g);
    repeat (3) begin tick(); n++; end
    write_reg(8'h01); n++;
    while (!clk_en && n < 100) begin tick(); n++; end
    check(n == 32, "R10 old period completes", n, 32);
    measure_gap(g);
    check(g == 2, "R10 new period after wrap", g, 2);
    write_reg(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_reserved();
    t_sleep();
    t_standby();
    t_watch();
    t_subclock();
    t_blocked();
    t_divide();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule